// File: doc/BRIEF.md
# Ping-Pong Stream-to-Memory DMA

This block moves a continuous stream of 32-bit words, such as ADC samples, into memory with no processor involvement. It owns two buffer slots, A and B. Each slot has its own base address and its own length in words. The engine fills one slot word by word. When that slot is full it moves on to the other slot, and it keeps alternating between the two for as long as it is enabled. Software reads the slot that the hardware is not writing. It learns which one that is from a status bit, and it is told of each handover by a per-slot done flag and an interrupt.

Words arrive on a valid/ready stream. Each accepted word becomes exactly one single-beat memory write, which holds address and data steady until the memory acknowledges it. Configuration and status sit in a small word-indexed register file with a combinational read port.

The controller is a four-state machine:
- `ST_IDLE`: the engine is stopped.
- `ST_SELECT`: the current slot is validated.
- `ST_WAIT`: the engine waits for a stream word with ready high.
- `ST_WRITE`: a memory write is outstanding.

Its transitions are:
- IDLE→SELECT when enable is set. This transition resets the engine to slot A, offset 0.
- SELECT→SELECT when the slot length is zero. The engine flags an error and swaps to the other slot.
- SELECT→WAIT when the slot length is valid. The overrun check is made on this transition.
- WAIT→WRITE when a word is accepted.
- WRITE→WAIT when a word is acknowledged and more words remain in the slot.
- WRITE→SELECT when the final word of the slot is acknowledged. The engine swaps slots on this transition.
- SELECT, WAIT or WRITE→IDLE once enable is clear. In WRITE this happens only after the acknowledge.

Top module: `pingpong_dma`

## Requirements
- R1: After reset, s_ready, mem_req and irq are 0, and every register reads 0. The register map by word index on cfg_addr is: 0 control, 1 status, 2 slot A base, 3 slot A length, 4 slot B base, 5 slot B length.
- R2: Each word accepted on the stream (s_valid and s_ready high at a clock edge) produces exactly one memory write, in order, carrying that word. The write address is slot base + 4 × offset, where offset counts the words already written into the current slot. Address and data hold steady while mem_req is high and mem_ack is low.
- R3: s_ready is low whenever mem_req is high.
- R4: When the write of a slot's final word (offset = length − 1) is acknowledged, the next write goes to the other slot at offset 0. A and B alternate endlessly.
- R5: Status bit 0 gives the slot being written: 0 for A, 1 for B.
- R6: Acknowledging the final word of a slot sets that slot's done flag (status bit 1 for A, bit 2 for B). irq is high while either done flag is set. Writing 1 to a status bit clears it, and a hardware set in the same cycle takes priority over the clear.
- R7: Status bit 3 (overrun) sets when the engine starts a slot whose done flag is still set. The writes into that slot proceed regardless.
- R8: A slot with length 0 is skipped in favour of the other slot, and status bit 4 (error) sets.
- R9: Control bit 0 enables the engine. Setting it starts at slot A, offset 0. Clearing it lets an outstanding write complete and then stops the engine. While the engine is stopped, s_ready stays low and no memory write is issued. Status bit 5 reads 1 while the engine is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Stream word available |
| s_ready | output | 1 | Engine can take a stream word |
| s_data | input | DW | Stream word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Memory byte address |
| mem_data | output | DW | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | RAW | Register word index |
| cfg_wdata | input | CW | Register write data |
| cfg_rdata | output | CW | Register read data (combinational) |
| irq | output | 1 | Buffer-ready interrupt |

## Verification
The assertions assume a memory that eventually acknowledges each request with a one-cycle mem_ack pulse, and that never acknowledges when no request is pending. They also assume that slot lengths are not rewritten while the engine is filling that slot. The bench's memory responder raises mem_ack only in answer to mem_req, with a rotating delay of zero to two cycles, and it always drops mem_ack after one edge. Lengths and bases are reprogrammed only while the engine is disabled. Status is read and cleared only after the engine has settled in WAIT.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SELECT,
        ST_WAIT,
        ST_WRITE
    } dma_state_e;

    localparam int NSLOT      = 2;
    localparam int REG_CTRL   = 0;
    localparam int REG_STAT   = 1;
    localparam int REG_BASE_A = 2;
    localparam int REG_LEN_A  = 3;

    // status bit positions
    localparam int ST_B_SLOT  = 0;
    localparam int ST_B_DONE0 = 1;
    localparam int ST_B_OVR   = 3;
    localparam int ST_B_ERR   = 4;
    localparam int ST_B_BUSY  = 5;
endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
    import pp_dma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int LW  = 16,
    parameter int RAW = 3,
    parameter int CW  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [RAW-1:0]              cfg_addr,
    input  logic [CW-1:0]               cfg_wdata,
    output logic [CW-1:0]               cfg_rdata,
    output logic                        ctrl_en,
    output logic [NSLOT-1:0][AW-1:0]    slot_base,
    output logic [NSLOT-1:0][LW-1:0]    slot_len,
    output logic [NSLOT-1:0]            done,
    output logic                        irq,
    input  logic [NSLOT-1:0]            set_done,
    input  logic                        set_ovr,
    input  logic                        set_err,
    input  logic                        act_slot,
    input  logic                        busy
);
    localparam logic [RAW-1:0] IDX_CTRL = RAW'(REG_CTRL);
    localparam logic [RAW-1:0] IDX_STAT = RAW'(REG_STAT);

    logic en_q, ovr_q, err_q;
    logic stat_wr;

    assign stat_wr = cfg_we && (cfg_addr == IDX_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ovr_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (cfg_we && cfg_addr == IDX_CTRL) en_q <= cfg_wdata[0];
            if (set_ovr)                           ovr_q <= 1'b1;
            else if (stat_wr && cfg_wdata[ST_B_OVR]) ovr_q <= 1'b0;
            if (set_err)                           err_q <= 1'b1;
            else if (stat_wr && cfg_wdata[ST_B_ERR]) err_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam logic [RAW-1:0] IDX_BASE = RAW'(REG_BASE_A + 2 * i);
        localparam logic [RAW-1:0] IDX_LEN  = RAW'(REG_LEN_A + 2 * i);
        logic [AW-1:0] base_q;
        logic [LW-1:0] len_q;
        logic          done_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                len_q  <= '0;
                done_q <= 1'b0;
            end else begin
                if (cfg_we && cfg_addr == IDX_BASE) base_q <= cfg_wdata[AW-1:0];
                if (cfg_we && cfg_addr == IDX_LEN)  len_q  <= cfg_wdata[LW-1:0];
                if (set_done[i])                             done_q <= 1'b1;
                else if (stat_wr && cfg_wdata[ST_B_DONE0 + i]) done_q <= 1'b0;
            end
        end

        assign slot_base[i] = base_q;
        assign slot_len[i]  = len_q;
        assign done[i]      = done_q;

        assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            set_done[i] |=> done_q);
        assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && cfg_wdata[ST_B_DONE0 + i] && !set_done[i]) |=> !done_q);
    end

    assign ctrl_en = en_q;
    assign irq     = |done;

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            RAW'(0): cfg_rdata[0] = en_q;
            RAW'(1): begin
                cfg_rdata[ST_B_SLOT]              = act_slot;
                cfg_rdata[ST_B_DONE0 +: NSLOT]    = done;
                cfg_rdata[ST_B_OVR]               = ovr_q;
                cfg_rdata[ST_B_ERR]               = err_q;
                cfg_rdata[ST_B_BUSY]              = busy;
            end
            RAW'(2): cfg_rdata[AW-1:0] = slot_base[0];
            RAW'(3): cfg_rdata[LW-1:0] = slot_len[0];
            RAW'(4): cfg_rdata[AW-1:0] = slot_base[1];
            RAW'(5): cfg_rdata[LW-1:0] = slot_len[1];
            default: cfg_rdata = '0;
        endcase
    end

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> err_q);
    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovr |=> ovr_q);
endmodule

// File: rtl/pp_dma_fsm.sv
module pp_dma_fsm
    import pp_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [NSLOT-1:0][AW-1:0]    slot_base,
    input  logic [NSLOT-1:0][LW-1:0]    slot_len,
    input  logic [NSLOT-1:0]            done,
    input  logic                        s_valid,
    output logic                        s_ready,
    input  logic [DW-1:0]               s_data,
    output logic                        mem_req,
    output logic [AW-1:0]               mem_addr,
    output logic [DW-1:0]               mem_data,
    input  logic                        mem_ack,
    output logic [NSLOT-1:0]            set_done,
    output logic                        set_ovr,
    output logic                        set_err,
    output logic                        act_slot,
    output logic                        busy
);
    dma_state_e    state_q, state_d;
    logic          slot_q, slot_d;
    logic [LW-1:0] off_q, off_d;
    logic [DW-1:0] data_q;
    logic [LW-1:0] cur_len;
    logic          last_word;

    assign cur_len   = slot_len[slot_q];
    assign last_word = (off_q == cur_len - LW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= 1'b0;
            off_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            off_q   <= off_d;
            if (s_valid && s_ready) data_q <= s_data;
        end
    end

    // next state and event pulses
    always_comb begin
        state_d  = state_q;
        slot_d   = slot_q;
        off_d    = off_q;
        set_done = '0;
        set_ovr  = 1'b0;
        set_err  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    state_d = ST_SELECT;
                    slot_d  = 1'b0;
                    off_d   = '0;
                end
            end
            ST_SELECT: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (cur_len == '0) begin
                    set_err = 1'b1;
                    slot_d  = ~slot_q;
                end else begin
                    set_ovr = done[slot_q];
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!en)          state_d = ST_IDLE;
                else if (s_valid) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    if (last_word) begin
                        set_done[slot_q] = 1'b1;
                        slot_d  = ~slot_q;
                        off_d   = '0;
                        state_d = en ? ST_SELECT : ST_IDLE;
                    end else begin
                        off_d   = off_q + LW'(1);
                        state_d = en ? ST_WAIT : ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_ready  = (state_q == ST_WAIT) && en;
        mem_req  = (state_q == ST_WRITE);
        mem_addr = slot_base[slot_q] + AW'({off_q, 2'b00});
        mem_data = data_q;
        act_slot = slot_q;
        busy     = (state_q != ST_IDLE);
    end

    assert_ready_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !s_ready);
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));
    assert_slot_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && last_word) |=> (act_slot != $past(act_slot)));
    assert_start_at_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && en) |=> (!act_slot && off_q == '0));
    assert_stop_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && state_q != ST_WRITE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma
    import pp_dma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int LW  = 16,
    parameter int RAW = 3,
    parameter int CW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s_valid,
    output logic           s_ready,
    input  logic [DW-1:0]  s_data,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_data,
    input  logic           mem_ack,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [CW-1:0]  cfg_wdata,
    output logic [CW-1:0]  cfg_rdata,
    output logic           irq
);
    logic                     ctrl_en;
    logic [NSLOT-1:0][AW-1:0] slot_base;
    logic [NSLOT-1:0][LW-1:0] slot_len;
    logic [NSLOT-1:0]         done;
    logic [NSLOT-1:0]         set_done;
    logic                     set_ovr, set_err, act_slot, busy;

    pp_dma_regs #(.AW(AW), .LW(LW), .RAW(RAW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctrl_en   (ctrl_en),
        .slot_base (slot_base),
        .slot_len  (slot_len),
        .done      (done),
        .irq       (irq),
        .set_done  (set_done),
        .set_ovr   (set_ovr),
        .set_err   (set_err),
        .act_slot  (act_slot),
        .busy      (busy)
    );

    pp_dma_fsm #(.AW(AW), .DW(DW), .LW(LW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_en),
        .slot_base (slot_base),
        .slot_len  (slot_len),
        .done      (done),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_data    (s_data),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_ack   (mem_ack),
        .set_done  (set_done),
        .set_ovr   (set_ovr),
        .set_err   (set_err),
        .act_slot  (act_slot),
        .busy      (busy)
    );
endmodule

// File: tb/sim_pingpong_dma.sv
module sim_pingpong_dma;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_ack = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    pingpong_dma u0 (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model
    logic [31:0] m_base [2];
    int          m_len  [2];
    bit          m_done [2];
    bit          m_ovr, m_err, m_en, m_entered;
    int          m_slot, m_off;
    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    int          q_last [$];
    int          pend_done = -1;
    logic [31:0] pend_clr = '0;
    int          ack_wait = 0;
    int          dly_pat = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // slot entry: skip zero-length slots, detect overrun (once per slot)
    task automatic enter_slot();
        if (m_off == 0 && !m_entered) begin
            while (m_len[m_slot] == 0) begin
                m_err  = 1;
                m_slot ^= 1;
            end
            if (m_done[m_slot]) m_ovr = 1;
            m_entered = 1;
        end
    endtask

    task automatic model_accept(logic [31:0] d);
        enter_slot();
        q_addr.push_back(m_base[m_slot] + 32'(4 * m_off));
        q_data.push_back(d);
        m_off++;
        if (m_off == m_len[m_slot]) begin
            q_last.push_back(m_slot);
            m_slot ^= 1;
            m_off = 0;
            m_entered = 0;
        end else begin
            q_last.push_back(-1);
        end
    endtask

    // memory responder and write comparison (R2)
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 0;
        end else if (mem_ack) begin
            mem_ack = 0;
        end else if (mem_req) begin
            if (ack_wait == 0) begin
                if (q_addr.size() == 0) begin
                    chk("R2 unexpected write", mem_addr, 32'hxxxxxxxx);
                    pend_done = -1;
                end else begin
                    chk("R2 addr", mem_addr, q_addr.pop_front());
                    chk("R2 data", mem_data, q_data.pop_front());
                    pend_done = q_last.pop_front();
                end
                mem_ack = 1;
                dly_pat = (dly_pat + 1) % 3;
                ack_wait = dly_pat;
            end else begin
                ack_wait--;
            end
        end
    end

    // per-clock comparison
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (pend_clr[1]) m_done[0] = 0;
            if (pend_clr[2]) m_done[1] = 0;
            if (pend_clr[3]) m_ovr = 0;
            if (pend_clr[4]) m_err = 0;
            pend_clr = '0;
            if (pend_done >= 0) m_done[pend_done] = 1;
            pend_done = -1;
            chk("R6 irq", 32'(irq), 32'(m_done[0] | m_done[1]));
            chk("R3 ready during req", 32'(s_ready & mem_req), 32'd0);
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = d;
        if (a == 1) pend_clr = d;
        if (a == 0) begin
            if (d[0] && !m_en) begin
                m_slot = 0; m_off = 0; m_entered = 0;
            end
            m_en = d[0];
        end
        if (a == 2) m_base[0] = d;
        if (a == 3) m_len[0]  = int'(d[15:0]);
        if (a == 4) m_base[1] = d;
        if (a == 5) m_len[1]  = int'(d[15:0]);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send(logic [31:0] d);
        s_valid = 1; s_data = d;
        forever begin
            if (s_ready) begin
                model_accept(d);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        s_valid = 0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic check_status(string tag);
        logic [31:0] exp;
        if (m_en) enter_slot();
        exp = '0;
        exp[0] = m_en ? m_slot[0] : 1'b0;
        exp[1] = m_done[0];
        exp[2] = m_done[1];
        exp[3] = m_ovr;
        exp[4] = m_err;
        exp[5] = m_en;
        @(negedge clk);
        cfg_addr = 3'd1;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    int word = 32'h100;

    task automatic burst(int n);
        for (int i = 0; i < n; i++) begin
            send(32'(word));
            word++;
            if (i % 3 == 2) @(negedge clk);
        end
        settle();
    endtask

    initial begin
        m_base[0] = 0; m_base[1] = 0; m_len[0] = 0; m_len[1] = 0;
        m_done[0] = 0; m_done[1] = 0;
        m_ovr = 0; m_err = 0; m_en = 0; m_entered = 0; m_slot = 0; m_off = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 s_ready", 32'(s_ready), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 irq", 32'(irq), 0);
        for (int a = 0; a < 6; a++) begin
            cfg_addr = 3'(a); #1;
            chk("R1 register", cfg_rdata, 0);
        end

        wr(2, 32'h1000); wr(3, 4);
        wr(4, 32'h2000); wr(5, 3);
        wr(0, 1);
        settle();
        check_status("R5 starts on A / R9 busy");
        burst(4);                                    // R4: A filled, now B
        check_status("R4 R5 R6 switch to B, done A");
        burst(3);                                    // B filled, back to A
        check_status("R6 done B");
        burst(2);                                    // A restarted with done A set
        check_status("R7 overrun on refill");
        wr(1, 32'h1E);                               // W1C all flags
        settle();
        check_status("R6 W1C clear");
        burst(9);                                    // wraps A->B->A again
        check_status("R4 endless alternation");
        wr(1, 32'h1E);

        // R9: disable during an outstanding write
        fork send(32'hCAFE0001); join_none
        while (!mem_req) @(negedge clk);
        wr(0, 0);
        settle();
        chk("R9 stopped mem_req", 32'(mem_req), 0);
        s_valid = 1; s_data = 32'hDEAD;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R9 no ready while disabled", 32'(s_ready), 0);
            chk("R9 no write while disabled", 32'(mem_req), 0);
        end
        s_valid = 0;
        wr(1, 32'h1E);
        settle();

        // R9 restart at A offset 0, R8 zero-length B skipped
        wr(5, 0);
        wr(0, 1);
        settle();
        burst(6);
        check_status("R8 skip zero slot");

        // R8 both slots zero: no writes, error flagged
        wr(0, 0);
        wr(1, 32'h1E);
        wr(3, 0);
        wr(0, 1);
        repeat (5) @(negedge clk);
        chk("R8 no ready with both zero", 32'(s_ready), 0);
        chk("R8 no write with both zero", 32'(mem_req), 0);
        cfg_addr = 3'd1; #1;
        chk("R8 error bit", 32'(cfg_rdata[4]), 1);
        wr(0, 0);
        settle();
        chk("R2 all writes seen", 32'(q_addr.size()), 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule